// File: doc/BRIEF.md
# General-purpose I/O port with edge and level interrupts

A 32-line general-purpose I/O port controlled through a small register bank on a single-cycle word-addressed bus. Each line can be turned into an output or an input, can drive a stored value or blink it, and can have its sampled level inverted before software or the interrupt logic sees it. The inversion also chooses what counts as an event: rising or falling edge, high or low level.

Incoming pin levels are resynchronised through two flops and then inverted as the polarity bits select. Software reads the result as the input word. A 0-to-1 change of that word latches a sticky per-line edge flag. Software acknowledges a flag by writing a zero to its bit. The level request and the edge request of each line have separate enables. All per-line requests are merged in blocks of eight lines onto four interrupt wires, one for each block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the edge flags, edge enables, level enables, output word, blink word and polarity word are all zero, and every line is an input, so `pin_oe` is 0, `pin_out` is 0 and `irq_grp` is 0.
- R2: A direction bit of 1 makes its line an input and 0 makes it an output (`pin_oe` = inverse of the direction word). With blink off, `pin_out` equals the output word.
- R3: The word addresses are 0 output, 1 direction, 2 blink, 3 polarity, 4 input, 5 edge flags, 6 edge enable and 7 level enable (byte offsets four times these). Read data appears on `bus_rdata` one clock after the address is presented. Writable registers read back what was written.
- R4: The input word (address 4) is the pin level after a two-flop synchroniser, XORed with the polarity word. Writes to address 4 change nothing.
- R5: A line's level request is its input-word bit AND its level-enable bit. Polarity 0 therefore requests on a high pin and polarity 1 on a low pin.
- R6: A 0-to-1 change of an input-word bit sets that line's edge flag, which then stays set while the pin returns. Polarity 0 catches rising pin edges and polarity 1 catches falling ones.
- R7: A write to address 5 clears every flag whose written bit is 0 and leaves every flag whose written bit is 1 untouched.
- R8: When a new edge and a clearing write hit the same flag in the same clock, the flag ends up set.
- R9: A line's edge request is its edge flag AND its edge-enable bit. It is ORed with the level request, and a flag whose enable is 0 raises no interrupt.
- R10: `irq_grp[g]` is the OR of the requests of lines 8g to 8g+7.
- R11: A line with its blink bit set drives its output bit ANDed with a free-running square wave that is low for `BLINK_HALF` clocks and then high for `BLINK_HALF` clocks. Lines without blink are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Output drive enables, 1 = drive |
| irq_grp | output | 4 | Merged interrupt for each block of eight lines |

## Verification
Edge capture is driven with a rising pin under polarity 0 and a falling pin under polarity 1. These two cases tell apart whether the inversion sits before or after the edge detector. A polarity change made while the pin is steady must raise no flag. Acknowledge patterns clear one flag out of two, which separates write-zero-to-clear from write-one-to-clear. A clearing write placed in the exact clock an edge arrives shows whether the set or the clear wins. Level requests are driven from pins in different blocks of eight, which shows whether each request reaches the right summary wire. Blink is observed against a steady neighbour pin, which separates the blink gating from the plain output path.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int GP_PINS = 32;

    typedef enum logic [2:0] {
        RG_DOUT  = 3'd0,
        RG_DIR   = 3'd1,
        RG_BLINK = 3'd2,
        RG_POL   = 3'd3,
        RG_DIN   = 3'd4,
        RG_FLAG  = 3'd5,
        RG_EEN   = 3'd6,
        RG_LEN   = 3'd7
    } gp_reg_e;

    typedef struct packed {
        logic [GP_PINS-1:0] dout;
        logic [GP_PINS-1:0] dir;
        logic [GP_PINS-1:0] blink;
        logic [GP_PINS-1:0] pol;
        logic [GP_PINS-1:0] edge_en;
        logic [GP_PINS-1:0] lvl_en;
    } gp_cfg_t;

    // next flag word: written zeros clear, new events always set
    function automatic logic [GP_PINS-1:0] flag_next(
        input logic [GP_PINS-1:0] cur,
        input logic [GP_PINS-1:0] rise,
        input logic               wr,
        input logic [GP_PINS-1:0] wdata
    );
        logic [GP_PINS-1:0] keep;
        keep = wr ? wdata : '1;
        return (cur & keep) | rise;
    endfunction

endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gp_blink.sv
module gp_blink #(
    parameter int HALF = 16
) (
    input  logic clk,
    input  logic rst,
    output logic wave
);
    localparam int CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            wave <= ~wave;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R11
    blink_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wave) |-> (cnt == '0));
endmodule

// File: rtl/gp_irq.sv
module gp_irq
    import gpio_port_pkg::*;
#(
    parameter int GROUP_W = 8,
    localparam int N_GRP = GP_PINS / GROUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GP_PINS-1:0] din,
    input  logic [GP_PINS-1:0] edge_en,
    input  logic [GP_PINS-1:0] lvl_en,
    input  logic               flag_wr,
    input  logic [GP_PINS-1:0] flag_wdata,
    output logic [GP_PINS-1:0] flags,
    output logic [N_GRP-1:0]   irq_grp
);
    logic [GP_PINS-1:0] din_prev;
    logic [GP_PINS-1:0] rise;
    logic [GP_PINS-1:0] req;

    assign rise = din & ~din_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_prev <= '0;
            flags    <= '0;
        end else begin
            din_prev <= din;
            flags    <= flag_next(flags, rise, flag_wr, flag_wdata);
        end
    end

    assign req = (din & lvl_en) | (flags & edge_en);

    for (genvar g = 0; g < N_GRP; g++) begin : g_merge
        assign irq_grp[g] = |req[g*GROUP_W +: GROUP_W];
    end

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> ((flags & ~($past(flag_wdata) | $past(rise))) == '0));
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> ((flags & $past(flags)) == $past(flags)));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((flags & $past(rise)) == $past(rise)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int GROUP_W    = 8,
    parameter int BLINK_HALF = 16,
    localparam int N_GRP     = GP_PINS / GROUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         bus_addr,
    input  logic               bus_we,
    input  logic [GP_PINS-1:0] bus_wdata,
    output logic [GP_PINS-1:0] bus_rdata,
    input  logic [GP_PINS-1:0] pin_in,
    output logic [GP_PINS-1:0] pin_out,
    output logic [GP_PINS-1:0] pin_oe,
    output logic [N_GRP-1:0]   irq_grp
);
    gp_cfg_t            cfg;
    gp_reg_e            sel;
    logic [GP_PINS-1:0] pin_s;
    logic [GP_PINS-1:0] din;
    logic [GP_PINS-1:0] flags;
    logic               wave;
    logic               flag_wr;

    assign sel     = gp_reg_e'(bus_addr);
    assign flag_wr = bus_we && (sel == RG_FLAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.dout    <= '0;
            cfg.dir     <= '1;
            cfg.blink   <= '0;
            cfg.pol     <= '0;
            cfg.edge_en <= '0;
            cfg.lvl_en  <= '0;
        end else if (bus_we) begin
            case (sel)
                RG_DOUT:  cfg.dout    <= bus_wdata;
                RG_DIR:   cfg.dir     <= bus_wdata;
                RG_BLINK: cfg.blink   <= bus_wdata;
                RG_POL:   cfg.pol     <= bus_wdata;
                RG_EEN:   cfg.edge_en <= bus_wdata;
                RG_LEN:   cfg.lvl_en  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            case (sel)
                RG_DOUT:  bus_rdata <= cfg.dout;
                RG_DIR:   bus_rdata <= cfg.dir;
                RG_BLINK: bus_rdata <= cfg.blink;
                RG_POL:   bus_rdata <= cfg.pol;
                RG_DIN:   bus_rdata <= din;
                RG_FLAG:  bus_rdata <= flags;
                RG_EEN:   bus_rdata <= cfg.edge_en;
                RG_LEN:   bus_rdata <= cfg.lvl_en;
                default:  bus_rdata <= '0;
            endcase
        end
    end

    gp_sync #(.W(GP_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    assign din = pin_s ^ cfg.pol;

    gp_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk  (clk),
        .rst  (rst),
        .wave (wave)
    );

    assign pin_out = cfg.dout & ~(cfg.blink & {GP_PINS{~wave}});
    assign pin_oe  = ~cfg.dir;

    gp_irq #(.GROUP_W(GROUP_W)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .edge_en    (cfg.edge_en),
        .lvl_en     (cfg.lvl_en),
        .flag_wr    (flag_wr),
        .flag_wdata (bus_wdata),
        .flags      (flags),
        .irq_grp    (irq_grp)
    );

    // R1
    mask_reset_chk: assert property (@(posedge clk)
        rst |=> (cfg.edge_en == '0 && cfg.lvl_en == '0 && flags == '0));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
    localparam int HALF = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [3:0]  irq_grp;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_irq_port #(.GROUP_W(8), .BLINK_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_grp(irq_grp)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq_grp", {28'h0, irq_grp}, 32'h0);
        rd(3'd5, v); check("R1 flags", v, 32'h0);
        rd(3'd6, v); check("R1 edge enable", v, 32'h0);
        rd(3'd7, v); check("R1 level enable", v, 32'h0);
    endtask

    task automatic t_dir_out();
        logic [31:0] v;
        wr(3'd1, 32'hFFFF_0000);
        wr(3'd0, 32'h1234_ABCD);
        check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
        check("R2 pin_out", pin_out, 32'h1234_ABCD);
        rd(3'd0, v); check("R3 output readback", v, 32'h1234_ABCD);
        rd(3'd1, v); check("R3 direction readback", v, 32'hFFFF_0000);
        wr(3'd6, 32'h0F0F_0F0F);
        rd(3'd6, v); check("R3 edge enable readback", v, 32'h0F0F_0F0F);
        wr(3'd6, 32'h0);
    endtask

    task automatic t_din();
        logic [31:0] v;
        pin_in = 32'hA5A5_0F0F; settle();
        rd(3'd4, v); check("R4 input pol 0", v, 32'hA5A5_0F0F);
        wr(3'd3, 32'hFFFF_0000);
        rd(3'd4, v); check("R4 input inverted", v, 32'h5A5A_0F0F);
        wr(3'd4, 32'h1234_5678);
        rd(3'd4, v); check("R4 write to input ignored", v, 32'h5A5A_0F0F);
        wr(3'd3, 32'h0);
        pin_in = 32'h0; settle();
        wr(3'd5, 32'h0);
    endtask

    task automatic t_level();
        wr(3'd7, 32'h0000_0100);
        pin_in = 32'h0000_0100; settle();
        check("R5 level high irq", {28'h0, irq_grp}, 32'h2);
        pin_in = 32'h0; settle();
        check("R5 level drop", {28'h0, irq_grp}, 32'h0);
        wr(3'd3, 32'h0000_0100);
        check("R5 level low via polarity", {28'h0, irq_grp}, 32'h2);
        wr(3'd3, 32'h0);
        wr(3'd7, 32'hFFFF_FFFF);
        pin_in = 32'h8000_0000; settle();
        check("R10 pin 31 to group 3", {28'h0, irq_grp}, 32'h8);
        pin_in = 32'h0000_0001; settle();
        check("R10 pin 0 to group 0", {28'h0, irq_grp}, 32'h1);
        pin_in = 32'h0001_0080; settle();
        check("R10 pins 7 and 16", {28'h0, irq_grp}, 32'h5);
        wr(3'd7, 32'h0);
        pin_in = 32'h0; settle();
        wr(3'd5, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(3'd6, 32'h0010_0000);
        pin_in = 32'h0010_0000; settle();
        check("R9 edge irq group 2", {28'h0, irq_grp}, 32'h4);
        rd(3'd5, v); check("R6 rising sets flag", v, 32'h0010_0000);
        pin_in = 32'h0; settle();
        rd(3'd5, v); check("R6 flag sticky", v, 32'h0010_0000);
        pin_in = 32'h0020_0000; settle();
        rd(3'd5, v); check("R6 second flag", v, 32'h0030_0000);
        wr(3'd5, ~32'h0010_0000);
        rd(3'd5, v); check("R7 ack one line", v, 32'h0020_0000);
        check("R9 disabled flag no irq", {28'h0, irq_grp}, 32'h0);
        pin_in = 32'h0; settle();
        wr(3'd5, 32'h0);
        wr(3'd6, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        pin_in = 32'h0200_0000; settle();
        wr(3'd3, 32'h0200_0000); settle();
        wr(3'd5, 32'h0);
        rd(3'd5, v); check("R6 polarity at steady high no flag", v, 32'h0);
        pin_in = 32'h0; settle();
        rd(3'd5, v); check("R6 falling edge with polarity 1", v, 32'h0200_0000);
        wr(3'd3, 32'h0); settle();
        wr(3'd5, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wr(3'd5, 32'h0);
        pin_in = 32'h0000_0020;
        @(negedge clk);
        @(negedge clk);
        wr(3'd5, 32'h0);
        rd(3'd5, v); check("R8 set beats clear", v, 32'h0000_0020);
        wr(3'd5, 32'h0);
        rd(3'd5, v); check("R7 clear by zero", v, 32'h0);
        pin_in = 32'h0; settle();
    endtask

    task automatic t_blink();
        int highs = 0;
        int steady_bad = 0;
        wr(3'd1, ~32'h0000_0018);
        wr(3'd0, 32'h0000_0018);
        wr(3'd2, 32'h0000_0008);
        check("R2 blink pin driven", pin_oe, 32'h0000_0018);
        for (int i = 0; i < 4*HALF; i++) begin
            @(negedge clk);
            if (pin_out[3]) highs++;
            if (!pin_out[4]) steady_bad++;
        end
        check("R11 blink high cycles", highs, 2*HALF);
        check("R11 non-blink pin steady", steady_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_dir_out();
        t_din();
        t_level();
        t_edge();
        t_fall();
        t_set_wins();
        t_blink();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule